// File: doc/BRIEF.md
# Pipeline Data Hazard Interlock

This block is the decode-stage interlock of a five-stage in-order pipeline (Fetch, Decode, Compute, Memory, Write). It is given the decoded fields of the instruction that sits in the fetch-to-decode buffer: two source register numbers, each with a flag that says whether the field is really read, plus its destination number, a register-write flag and a load flag. It keeps its own record of the destination, write flag and load flag of the three older instructions now in Compute, Memory and Write. Each clock it moves that record one place down the pipe. If the waiting instruction reads a register that an older instruction has yet to write, the block asks the pipeline to keep the program counter and the fetch-to-decode buffer as they are. In the same cycle it has no-operation control settings loaded into the decode-to-compute buffer.

A parameter picks the policy. Without forwarding, the consumer waits until its producer has finished its register-file write in the Write stage. It may then read the register in the cycle that follows. With forwarding, the only pair that waits is a load followed at once by an instruction that uses the loaded register, and that pair waits for one cycle. A separate memory-busy input, raised while a data access takes more than one cycle, freezes every stage up to Memory. While it is high, the Write stage receives a bubble.

Top module: `dhaz_interlock`

## Requirements
- R1: After reset the record of older instructions is empty. With `fd_valid` and `mem_busy` low, all four outputs are 0, and the first instruction presented does not stall.
- R2: A stored producer counts only if its write flag was set. A source field counts only if its use flag is set. A producer without the write flag, or a matching field whose use flag is 0, causes no stall.
- R3: No-forwarding policy (POLICY=0): a consumer that directly follows its producer stalls for exactly three cycles.
- R4: No-forwarding policy: a consumer two places behind its producer stalls for two cycles and one three places behind stalls for one. A consumer four or more places behind does not stall.
- R5: Forwarding policy (POLICY=1): a consumer that directly follows a load writing one of its sources stalls for exactly one cycle. A non-load producer right ahead causes no stall, and neither does a load two places ahead.
- R6: On every hazard cycle `stall_front` and `dx_bubble` are both high, so the front end holds the consumer while a no-operation enters Compute. In a run without memory-busy cycles, the number of stall cycles equals the number of bubbles.
- R7: While `mem_busy` is high, `stall_front`, `back_hold` and `wb_bubble` are 1 and `dx_bubble` is 0. The Compute and Memory entries of the record do not move. Once `mem_busy` falls, a pending hazard continues for the cycles it still has left.
- R8: With `fd_valid` low and `mem_busy` low there is no stall, and the empty slot moves down the pipe as a non-writing entry. This shortens the wait of a later consumer.
- R9: Either source field, the first or the second, can raise the hazard.
- R10: Bubbles never count as producers. After its stall, a consumer enters Compute once with its own write flag and acts as a normal producer for the instructions behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fd_valid | input | 1 | The fetch-to-decode buffer holds an instruction |
| fd_rs1 | input | REG_W | First source register number |
| fd_use_rs1 | input | 1 | First source field is read |
| fd_rs2 | input | REG_W | Second source register number |
| fd_use_rs2 | input | 1 | Second source field is read |
| fd_rd | input | REG_W | Destination register number |
| fd_wr_en | input | 1 | Instruction writes the register file |
| fd_is_load | input | 1 | Instruction is a memory load |
| mem_busy | input | 1 | Memory stage access is not yet complete |
| stall_front | output | 1 | Hold the program counter and the fetch-to-decode buffer |
| dx_bubble | output | 1 | Load no-operation settings into the decode-to-compute buffer |
| back_hold | output | 1 | Hold the decode-to-compute and compute-to-memory buffers |
| wb_bubble | output | 1 | Feed a no-operation into the Write stage |

## Verification
The bench builds two instances side by side: one with REG_W=5 and the no-forwarding policy, and one with REG_W=5 and the forwarding policy. The first instance covers the three-, two- and one-cycle waits by producer distance, along with empty slots and chained consumers. The second covers the single load-use cycle and shows that non-load or more distant producers pass with no stall. Both instances get memory-busy windows placed inside a hazard, which shows that a freeze keeps the remaining wait intact rather than using it up.

// File: rtl/hz_pkg.sv
package hz_pkg;

   localparam int unsigned HZ_NSTG = 3;

   typedef enum int unsigned {
      HZ_EX  = 0,
      HZ_MEM = 1,
      HZ_WB  = 2
   } hz_stage_e;

   typedef enum logic {
      POL_STALL_ONLY = 1'b0,
      POL_FORWARD    = 1'b1
   } hz_policy_e;

   // longest run of bubbles a single consumer can see under a policy
   function automatic int unsigned max_bubbles(hz_policy_e p);
      return (p == POL_FORWARD) ? 1 : HZ_NSTG;
   endfunction

endpackage

// File: rtl/hz_tag_match.sv
module hz_tag_match #(
   parameter int unsigned REG_W = 5
) (
   input  logic [REG_W-1:0] src_a,
   input  logic             use_a,
   input  logic [REG_W-1:0] src_b,
   input  logic             use_b,
   input  logic [REG_W-1:0] dst,
   input  logic             dst_wr,
   output logic             hit
);

   logic hit_a;
   logic hit_b;

   always_comb begin
      hit_a = use_a && (src_a == dst);
      hit_b = use_b && (src_b == dst);
      hit   = dst_wr && (hit_a || hit_b);
   end

endmodule

// File: rtl/hz_tag_pipe.sv
module hz_tag_pipe #(
   parameter int unsigned REG_W = 5,
   parameter int unsigned NSTG  = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       freeze,
   input  logic                       issue,
   input  logic [REG_W-1:0]           in_rd,
   input  logic                       in_wr,
   input  logic                       in_ld,
   output logic [NSTG-1:0][REG_W-1:0] st_rd,
   output logic [NSTG-1:0]            st_wr,
   output logic                       ex_ld
);

   localparam int unsigned LAST = NSTG - 1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_rd <= '0;
         st_wr <= '0;
         ex_ld <= 1'b0;
      end else if (freeze) begin
         // stages up to Memory hold; Write receives an empty slot
         st_wr[LAST] <= 1'b0;
      end else begin
         st_rd[0] <= in_rd;
         st_wr[0] <= issue & in_wr;
         ex_ld    <= issue & in_ld;
         for (int k = 1; k < NSTG; k++) begin
            st_rd[k] <= st_rd[k-1];
            st_wr[k] <= st_wr[k-1];
         end
      end
   end

endmodule

// File: rtl/hz_policy.sv
module hz_policy
   import hz_pkg::*;
#(
   parameter int unsigned NSTG   = 3,
   parameter hz_policy_e  POLICY = POL_STALL_ONLY
) (
   input  logic            cand,
   input  logic [NSTG-1:0] hits,
   input  logic            ex_ld,
   output logic            hazard
);

   generate
      if (POLICY == POL_FORWARD) begin : g_fwd
         // only a load right ahead cannot be bypassed in time
         logic unused_far;
         assign hazard     = cand & hits[int'(HZ_EX)] & ex_ld;
         assign unused_far = ^hits[NSTG-1:1];
      end else begin : g_wait
         // wait until no older writer of a source is left in flight
         logic unused_ld;
         assign hazard    = cand & (|hits);
         assign unused_ld = ex_ld;
      end
   endgenerate

endmodule

// File: rtl/dhaz_interlock.sv
module dhaz_interlock
   import hz_pkg::*;
#(
   parameter int unsigned REG_W  = 5,
   parameter hz_policy_e  POLICY = POL_STALL_ONLY
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fd_valid,
   input  logic [REG_W-1:0] fd_rs1,
   input  logic             fd_use_rs1,
   input  logic [REG_W-1:0] fd_rs2,
   input  logic             fd_use_rs2,
   input  logic [REG_W-1:0] fd_rd,
   input  logic             fd_wr_en,
   input  logic             fd_is_load,
   input  logic             mem_busy,
   output logic             stall_front,
   output logic             dx_bubble,
   output logic             back_hold,
   output logic             wb_bubble
);

   localparam int unsigned NSTG = HZ_NSTG;

   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_width
         $error("dhaz_interlock: REG_W must lie in 1..8");
      end
   endgenerate

   logic [NSTG-1:0][REG_W-1:0] st_rd;
   logic [NSTG-1:0]            st_wr;
   logic                       ex_ld;
   logic [NSTG-1:0]            hits;
   logic                       hazard;
   logic                       issue;

   assign issue = fd_valid & ~hazard;

   hz_tag_pipe #(
      .REG_W (REG_W),
      .NSTG  (NSTG)
   ) u_pipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .freeze (mem_busy),
      .issue  (issue),
      .in_rd  (fd_rd),
      .in_wr  (fd_wr_en),
      .in_ld  (fd_is_load),
      .st_rd  (st_rd),
      .st_wr  (st_wr),
      .ex_ld  (ex_ld)
   );

   generate
      for (genvar s = 0; s < NSTG; s++) begin : g_cmp
         hz_tag_match #(
            .REG_W (REG_W)
         ) u_match (
            .src_a  (fd_rs1),
            .use_a  (fd_use_rs1),
            .src_b  (fd_rs2),
            .use_b  (fd_use_rs2),
            .dst    (st_rd[s]),
            .dst_wr (st_wr[s]),
            .hit    (hits[s])
         );
      end
   endgenerate

   hz_policy #(
      .NSTG   (NSTG),
      .POLICY (POLICY)
   ) u_pol (
      .cand   (fd_valid),
      .hits   (hits),
      .ex_ld  (ex_ld),
      .hazard (hazard)
   );

   assign stall_front = mem_busy | hazard;
   assign dx_bubble   = hazard & ~mem_busy;
   assign back_hold   = mem_busy;
   assign wb_bubble   = mem_busy;

endmodule

// File: rtl/dhaz_interlock_chk.sv
module dhaz_interlock_chk
   import hz_pkg::*;
#(
   parameter hz_policy_e POLICY = POL_STALL_ONLY
) (
   input logic clk,
   input logic rst_n,
   input logic fd_valid,
   input logic mem_busy,
   input logic stall_front,
   input logic dx_bubble,
   input logic back_hold,
   input logic wb_bubble
);

   localparam int unsigned MAXB = max_bubbles(POLICY);
   localparam int unsigned CW   = $clog2(MAXB + 1);

   // bubbles already issued for the consumer now held in decode
   logic [CW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            run_q <= '0;
      else if (!stall_front) run_q <= '0;
      else if (dx_bubble)    run_q <= run_q + 1'b1;
   end

   AST_BUBBLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      dx_bubble |-> (32'(run_q) < MAXB)); // R3

   AST_BUBBLE_HOLDS_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
      dx_bubble |-> (stall_front && !back_hold)); // R6

   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_busy |-> (stall_front && back_hold && wb_bubble && !dx_bubble)); // R7

   AST_EMPTY_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!fd_valid && !mem_busy) |-> !stall_front); // R8

endmodule

bind dhaz_interlock dhaz_interlock_chk #(.POLICY(POLICY)) u_chk (.*);

// File: tb/dhaz_interlock_test.sv
`timescale 1ns/100ps
module dhaz_interlock_test;
   import hz_pkg::*;

   typedef struct {
      bit v;
      int rd;
      bit wen;
      bit ld;
      int rs1;
      bit u1;
      int rs2;
      bit u2;
   } ins_t;

   typedef struct {
      bit wen;
      bit ld;
      int rd;
   } ent_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       fdv [2];
   logic [4:0] rs1 [2];
   logic       u1  [2];
   logic [4:0] rs2 [2];
   logic       u2  [2];
   logic [4:0] rd  [2];
   logic       wen [2];
   logic       ld  [2];
   logic       busy[2];
   logic       o_st[2];
   logic       o_bb[2];
   logic       o_hd[2];
   logic       o_wb[2];

   dhaz_interlock #(.REG_W(5), .POLICY(POL_STALL_ONLY)) uut (
      .clk(clk), .rst_n(rst_n), .fd_valid(fdv[0]), .fd_rs1(rs1[0]),
      .fd_use_rs1(u1[0]), .fd_rs2(rs2[0]), .fd_use_rs2(u2[0]), .fd_rd(rd[0]),
      .fd_wr_en(wen[0]), .fd_is_load(ld[0]), .mem_busy(busy[0]),
      .stall_front(o_st[0]), .dx_bubble(o_bb[0]), .back_hold(o_hd[0]),
      .wb_bubble(o_wb[0]));

   dhaz_interlock #(.REG_W(5), .POLICY(POL_FORWARD)) uut_fwd (
      .clk(clk), .rst_n(rst_n), .fd_valid(fdv[1]), .fd_rs1(rs1[1]),
      .fd_use_rs1(u1[1]), .fd_rs2(rs2[1]), .fd_use_rs2(u2[1]), .fd_rd(rd[1]),
      .fd_wr_en(wen[1]), .fd_is_load(ld[1]), .mem_busy(busy[1]),
      .stall_front(o_st[1]), .dx_bubble(o_bb[1]), .back_hold(o_hd[1]),
      .wb_bubble(o_wb[1]));

   int   n_chk = 0;
   int   n_fail = 0;
   ins_t prog[$];
   int   n_stall;
   int   n_bub;

   function automatic ins_t mk(bit v, int d, bit w, bit l, int a, bit ua, int b, bit ub);
      ins_t x;
      x.v = v; x.rd = d; x.wen = w; x.ld = l;
      x.rs1 = a; x.u1 = ua; x.rs2 = b; x.u2 = ub;
      return x;
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic expect_eq(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs(int m);
      fdv[m] = 0; rs1[m] = 0; u1[m] = 0; rs2[m] = 0; u2[m] = 0;
      rd[m] = 0; wen[m] = 0; ld[m] = 0; busy[m] = 0;
   endtask

   // plays prog on instance m; mem_busy high for run cycles busy_lo..busy_hi
   task automatic run_prog(int m, string req, int busy_lo, int busy_hi);
      ent_t pipe[$];
      ent_t nop;
      int   pc = 0;
      int   drain = 0;
      int   t = 0;
      nop.wen = 0; nop.ld = 0; nop.rd = 0;
      pipe = {nop, nop, nop};
      n_stall = 0;
      n_bub = 0;
      while (pc < prog.size() || drain < 4) begin
         ins_t cur;
         ent_t nx;
         bit   bz;
         bit   hz;
         bit   e_st;
         bit   e_bb;
         @(negedge clk);
         if (pc < prog.size()) cur = prog[pc];
         else cur = mk(0, 0, 0, 0, 0, 0, 0, 0);
         bz = (t >= busy_lo) && (t <= busy_hi);
         fdv[m] = cur.v; rs1[m] = 5'(cur.rs1); u1[m] = cur.u1;
         rs2[m] = 5'(cur.rs2); u2[m] = cur.u2; rd[m] = 5'(cur.rd);
         wen[m] = cur.wen; ld[m] = cur.ld; busy[m] = bz;
         hz = 0;
         for (int i = 0; i < 3; i++) begin
            bit uses;
            uses = (cur.u1 && cur.rs1 == pipe[i].rd) || (cur.u2 && cur.rs2 == pipe[i].rd);
            if (m == 1 && !(i == 0 && pipe[i].ld)) continue;
            if (cur.v && pipe[i].wen && uses) hz = 1;
         end
         e_st = bz | hz;
         e_bb = hz & !bz;
         #1;
         n_chk++;
         if (o_st[m] !== e_st || o_bb[m] !== e_bb || o_hd[m] !== bz || o_wb[m] !== bz) begin
            n_fail++;
            $display("FAIL %s inst%0d cycle %0d: actual st/bb/hd/wb=%b%b%b%b expected=%b%b%b%b",
                     req, m, t, o_st[m], o_bb[m], o_hd[m], o_wb[m], e_st, e_bb, bz, bz);
         end
         if (e_st) n_stall++;
         if (e_bb) n_bub++;
         if (bz) begin
            pipe[2] = nop;
         end else begin
            if (cur.v && !hz) begin
               nx.wen = cur.wen; nx.ld = cur.ld; nx.rd = cur.rd;
            end else nx = nop;
            pipe.push_front(nx);
            void'(pipe.pop_back());
         end
         if (!e_st) begin
            if (pc < prog.size()) pc++;
            else drain++;
         end
         t++;
      end
      @(negedge clk);
      idle_inputs(m);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: actual=%0d cycles expected=finish", 20000);
      summary();
      $finish;
   end

   initial begin
      idle_inputs(0);
      idle_inputs(1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      for (int m = 0; m < 2; m++) begin
         expect_eq("R1", "reset stall_front", int'(o_st[m]), 0);
         expect_eq("R1", "reset dx_bubble", int'(o_bb[m]), 0);
         expect_eq("R1", "reset back_hold", int'(o_hd[m]), 0);
         expect_eq("R1", "reset wb_bubble", int'(o_wb[m]), 0);
      end

      // no-forwarding instance
      prog = {mk(1,2,1,0,7,1,8,1), mk(1,9,1,0,2,1,0,0)};
      run_prog(0, "R3", -1, -1);
      expect_eq("R3", "adjacent stall cycles", n_stall, 3);
      expect_eq("R6", "bubbles equal stalls", n_bub, n_stall);

      prog = {mk(1,2,1,0,0,0,0,0), mk(1,4,1,0,5,1,0,0), mk(1,9,1,0,2,1,0,0)};
      run_prog(0, "R4", -1, -1);
      expect_eq("R4", "distance two stalls", n_stall, 2);

      prog = {mk(1,2,1,0,0,0,0,0), mk(1,4,1,0,0,0,0,0), mk(1,5,1,0,0,0,0,0),
              mk(1,9,1,0,2,1,0,0)};
      run_prog(0, "R4", -1, -1);
      expect_eq("R4", "distance three stalls", n_stall, 1);

      prog = {mk(1,2,1,0,0,0,0,0), mk(1,4,1,0,0,0,0,0), mk(1,5,1,0,0,0,0,0),
              mk(1,6,1,0,0,0,0,0), mk(1,9,1,0,2,1,0,0)};
      run_prog(0, "R4", -1, -1);
      expect_eq("R4", "distance four stalls", n_stall, 0);

      prog = {mk(1,2,0,0,0,0,0,0), mk(1,9,1,0,2,1,0,0)};
      run_prog(0, "R2", -1, -1);
      expect_eq("R2", "non-writing producer stalls", n_stall, 0);

      prog = {mk(1,2,1,0,0,0,0,0), mk(1,9,1,0,2,0,3,1)};
      run_prog(0, "R2", -1, -1);
      expect_eq("R2", "unused field stalls", n_stall, 0);

      prog = {mk(1,3,1,0,0,0,0,0), mk(1,9,1,0,1,1,3,1)};
      run_prog(0, "R9", -1, -1);
      expect_eq("R9", "second source stalls", n_stall, 3);

      prog = {mk(1,2,1,0,0,0,0,0), mk(1,9,1,0,2,1,0,0)};
      run_prog(0, "R7", 2, 3);
      expect_eq("R7", "bubbles around freeze", n_bub, 3);
      expect_eq("R7", "stalls around freeze", n_stall, 5);

      prog = {mk(1,2,1,0,0,0,0,0), mk(0,0,0,0,0,0,0,0), mk(0,0,0,0,0,0,0,0),
              mk(1,9,1,0,2,1,0,0)};
      run_prog(0, "R8", -1, -1);
      expect_eq("R8", "stalls after empty slots", n_stall, 1);

      prog = {mk(1,2,1,0,0,0,0,0), mk(1,6,1,0,2,1,0,0), mk(1,9,1,0,6,1,0,0)};
      run_prog(0, "R10", -1, -1);
      expect_eq("R10", "chained consumer stalls", n_stall, 6);

      // forwarding instance
      prog = {mk(1,2,1,1,3,1,0,0), mk(1,9,1,0,2,1,0,0)};
      run_prog(1, "R5", -1, -1);
      expect_eq("R5", "load-use stalls", n_stall, 1);

      prog = {mk(1,2,1,0,3,1,0,0), mk(1,9,1,0,2,1,0,0)};
      run_prog(1, "R5", -1, -1);
      expect_eq("R5", "alu-use stalls", n_stall, 0);

      prog = {mk(1,2,1,1,3,1,0,0), mk(1,4,1,0,0,0,0,0), mk(1,9,1,0,0,0,2,1)};
      run_prog(1, "R5", -1, -1);
      expect_eq("R5", "load distance two stalls", n_stall, 0);

      prog = {mk(1,2,1,1,3,1,0,0), mk(1,9,1,0,2,1,0,0)};
      run_prog(1, "R7", 1, 1);
      expect_eq("R7", "fwd bubbles around freeze", n_bub, 1);
      expect_eq("R7", "fwd stalls around freeze", n_stall, 2);

      summary();
      $finish;
   end

endmodule